// File: doc/BRIEF.md
# Pulse-Position Command Symbol Decoder

This block turns the reader-to-tag command stream into bytes. An upstream timing-recovery stage hands it one value per slot, qualified by `slot_valid`. A low value marks a pause in the carrier and a high value marks no pause. The block keeps a history of the last eight slot values and waits for a frame-start pattern. Once framed, it judges each following group of eight slots as a whole. A group with a single pause in one of four positions carries a two-bit symbol. One further single-pause position closes the frame. Any other group aborts the frame.

Symbols are packed into bytes least-significant pair first. Every completed byte is announced with a one-cycle strobe, and the count of bytes in the frame runs alongside. The count stops at a configurable ceiling and raises a sticky overflow flag. End of frame and a malformed group each produce a one-cycle pulse. After either one the block hunts for a new frame start. Cycles with `slot_valid` low are simply skipped. The block does not check CRC.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: During and after synchronous reset, `byte_valid`, `frame_done`, `sym_err`, `len_ovf` and `byte_len` are all zero, and the block hunts for a frame start.
- R2: A frame starts only when the last eight accepted slot values, oldest in bit 7, equal 0x7B (slot sequence 0,1,1,1,1,0,1,1). Until then no group is decoded and no output pulse occurs.
- R3: In a frame, each group of eight accepted slots is read with its first slot in bit 7. 0xBF gives symbol 0, 0xEF gives 1, 0xFB gives 2 and 0xFE gives 3.
- R4: Four symbols make one byte. The first symbol lands in bits 1:0 and the fourth in bits 7:6. `byte_valid` is high for exactly one cycle, the cycle after the slot that completes the fourth symbol, and `byte_data` holds the byte in that cycle.
- R5: A group equal to 0xDF ends the frame. `frame_done` pulses for one cycle after its eighth slot, and later groups are ignored until a new frame start.
- R6: Any other group pulses `sym_err` for one cycle after its eighth slot. The frame is abandoned without `frame_done`, and later groups are ignored until a new frame start.
- R7: Symbols that do not fill a byte when the frame ends produce no strobe.
- R8: `byte_len` counts the bytes strobed in the current frame. It is cleared when a frame start is seen, changes in the same cycle as the strobe, and holds after the frame ends.
- R9: `byte_len` saturates at MAX_LEN (default 32). The strobe of byte MAX_LEN+1 sets `len_ovf` in the same cycle. Further bytes are still strobed, and `len_ovf` stays set until the next frame start.
- R10: A cycle with `slot_valid` low changes nothing: the history, the group position, the outputs and `byte_len` are unaffected.
- R11: After every judged group the slot history is refilled with ones, so a frame-start pattern cannot borrow slots from the group just judged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | A slot value is presented this cycle |
| slot_bit | input | 1 | Slot value, 0 = pause |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, valid with `byte_valid` |
| byte_len | output | $clog2(MAX_LEN+1) | Bytes in the current frame, saturating |
| len_ovf | output | 1 | Sticky flag: more than MAX_LEN bytes in this frame |
| frame_done | output | 1 | One-cycle pulse at end of frame |
| sym_err | output | 1 | One-cycle pulse for a malformed group |

## Verification
Two functions can fall in the same cycle: the byte strobe of the (MAX_LEN+1)-th byte and the rise of the overflow flag, with the length held at its ceiling. The bench provokes this by sending a frame of MAX_LEN+1 bytes. It checks that strobe, flag and length all appear at the sample after the last slot of that byte, and that at byte MAX_LEN the flag is still low. It also checks that the next frame start clears both the flag and the length.

// File: rtl/ppm_dec_pkg.sv
package ppm_dec_pkg;

    // Slots per judged group and bits per symbol are fixed by the line code.
    localparam int WIN_SLOTS = 8;
    localparam int SYM_W     = 2;
    localparam int NUM_SYMS  = 1 << SYM_W;

    localparam logic [WIN_SLOTS-1:0] HIST_FILL = '1;
    localparam logic [WIN_SLOTS-1:0] SOF_CODE  = 8'h7B;
    localparam logic [WIN_SLOTS-1:0] EOF_CODE  = 8'hDF;

    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_END  = 2'd1,
        WK_BAD  = 2'd2
    } win_kind_e;

    typedef struct packed {
        win_kind_e        kind;
        logic [SYM_W-1:0] sym;
    } win_class_t;

    typedef enum logic {
        FS_HUNT  = 1'b0,
        FS_FRAME = 1'b1
    } frame_st_e;

    // Code for a symbol: one pause, moving two slots later per symbol step.
    function automatic logic [WIN_SLOTS-1:0] sym_code(input logic [SYM_W-1:0] s);
        logic [WIN_SLOTS-1:0] pause;
        pause    = 8'b0100_0000 >> {s, 1'b0};
        sym_code = ~pause;
    endfunction

    function automatic win_class_t classify(input logic [WIN_SLOTS-1:0] w);
        win_class_t res;
        res.kind = WK_BAD;
        res.sym  = '0;
        for (int i = 0; i < NUM_SYMS; i++) begin
            if (w == sym_code(SYM_W'(i))) begin
                res.kind = WK_DATA;
                res.sym  = SYM_W'(i);
            end
        end
        if (w == EOF_CODE) begin
            res.kind = WK_END;
        end
        return res;
    endfunction

endpackage

// File: rtl/ppm_slot_history.sv
module ppm_slot_history
    import ppm_dec_pkg::*;
#(
    parameter int WIN = WIN_SLOTS,
    localparam int CNT_W = $clog2(WIN)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slot_valid,
    input  logic           slot_bit,
    input  logic           count_en,
    input  logic           count_clr,
    input  logic           reload,
    output logic [WIN-1:0] hist_next,
    output logic           win_last
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN - 1);

    logic [WIN-1:0]   hist_q;
    logic [CNT_W-1:0] pos_q;

    // History as it stands once the current slot is included.
    assign hist_next = {hist_q[WIN-2:0], slot_bit};
    assign win_last  = (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
            pos_q  <= '0;
        end else if (slot_valid) begin
            hist_q <= reload ? {WIN{1'b1}} : hist_next;
            if (count_clr) begin
                pos_q <= '0;
            end else if (count_en) begin
                pos_q <= win_last ? '0 : pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppm_window_classifier.sv
module ppm_window_classifier
    import ppm_dec_pkg::*;
(
    input  logic [WIN_SLOTS-1:0] window,
    output win_class_t           verdict
);

    always_comb begin
        verdict = classify(window);
    end

endmodule

// File: rtl/ppm_byte_packer.sv
module ppm_byte_packer
    import ppm_dec_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int NSYM   = BYTE_W / SYM_W,
    localparam int SCNT_W = $clog2(NSYM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [SYM_W-1:0]  sym,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              ovf_q
);

    localparam logic [LEN_W-1:0]  LEN_CEIL = LEN_W'(MAX_LEN);
    localparam logic [SCNT_W-1:0] SYM_LAST = SCNT_W'(NSYM - 1);

    logic [BYTE_W-1:0] asm_q;
    logic [BYTE_W-1:0] asm_next;
    logic [SCNT_W-1:0] scnt_q;
    logic              fill_done;

    // New symbol enters at the top, older pairs move toward bit 0.
    assign asm_next  = {sym, asm_q[BYTE_W-1:SYM_W]};
    assign fill_done = (scnt_q == SYM_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q    <= '0;
            scnt_q   <= '0;
            byte_stb <= 1'b0;
            byte_q   <= '0;
            len_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (clr) begin
                asm_q  <= '0;
                scnt_q <= '0;
                len_q  <= '0;
                ovf_q  <= 1'b0;
            end else if (take) begin
                asm_q  <= asm_next;
                scnt_q <= fill_done ? '0 : scnt_q + 1'b1;
                if (fill_done) begin
                    byte_stb <= 1'b1;
                    byte_q   <= asm_next;
                    if (len_q == LEN_CEIL) begin
                        ovf_q <= 1'b1;
                    end else begin
                        len_q <= len_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder
    import ppm_dec_pkg::*;
#(
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_valid,
    input  logic             slot_bit,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic [LEN_W-1:0] byte_len,
    output logic             len_ovf,
    output logic             frame_done,
    output logic             sym_err
);

    frame_st_e            state_q;
    logic [WIN_SLOTS-1:0] hist_next;
    logic                 win_last;
    logic                 in_frame;
    logic                 sof_hit;
    logic                 win_end;
    logic                 sym_take;
    win_class_t           verdict;
    logic                 done_q;
    logic                 err_q;

    assign in_frame = (state_q == FS_FRAME);
    assign sof_hit  = !in_frame && slot_valid && (hist_next == SOF_CODE);
    assign win_end  = in_frame && slot_valid && win_last;
    assign sym_take = win_end && (verdict.kind == WK_DATA);

    ppm_slot_history #(.WIN(WIN_SLOTS)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .slot_valid (slot_valid),
        .slot_bit   (slot_bit),
        .count_en   (in_frame),
        .count_clr  (sof_hit),
        .reload     (win_end),
        .hist_next  (hist_next),
        .win_last   (win_last)
    );

    ppm_window_classifier u_cls (
        .window  (hist_next),
        .verdict (verdict)
    );

    ppm_byte_packer #(.BYTE_W(8), .MAX_LEN(MAX_LEN)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clr      (sof_hit),
        .take     (sym_take),
        .sym      (verdict.sym),
        .byte_stb (byte_valid),
        .byte_q   (byte_data),
        .len_q    (byte_len),
        .ovf_q    (len_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_HUNT;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= win_end && (verdict.kind == WK_END);
            err_q  <= win_end && (verdict.kind == WK_BAD);
            if (sof_hit) begin
                state_q <= FS_FRAME;
            end else if (win_end && (verdict.kind != WK_DATA)) begin
                state_q <= FS_HUNT;
            end
        end
    end

    assign frame_done = done_q;
    assign sym_err    = err_q;

endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
module ppm_cmd_decoder_chk #(
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_valid,
    input logic             byte_valid,
    input logic [LEN_W-1:0] byte_len,
    input logic             len_ovf,
    input logic             frame_done,
    input logic             sym_err
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R5

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!sym_err && !byte_valid)); // R5

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sym_err |=> !sym_err); // R6

    AST_LEN_CEIL: assert property (@(posedge clk) disable iff (rst)
        len_ovf |-> (byte_len == LEN_W'(MAX_LEN))); // R9

    AST_OVF_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(len_ovf) |-> byte_valid); // R9

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |=> (!byte_valid && !frame_done && !sym_err
                         && $stable(byte_len) && $stable(len_ovf))); // R10

endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (slot_valid),
    .byte_valid (byte_valid),
    .byte_len   (byte_len),
    .len_ovf    (len_ovf),
    .frame_done (frame_done),
    .sym_err    (sym_err)
);

// File: tb/sim_ppm_cmd_decoder.sv
`timescale 1ns/1ps
module sim_ppm_cmd_decoder;

    localparam int MAX_LEN = 32;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slot_valid = 1'b0;
    logic             slot_bit = 1'b1;
    logic             byte_valid;
    logic [7:0]       byte_data;
    logic [LEN_W-1:0] byte_len;
    logic             len_ovf;
    logic             frame_done;
    logic             sym_err;

    always #4 clk = ~clk;

    ppm_cmd_decoder #(.MAX_LEN(MAX_LEN)) u0 (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_bit(slot_bit),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_len(byte_len),
        .len_ovf(len_ovf), .frame_done(frame_done), .sym_err(sym_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;
    bit use_gaps = 0;

    // Event monitor, sampling well after the active edge.
    logic [7:0] got [0:255];
    int got_n  = 0;
    int done_n = 0;
    int err_n  = 0;

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (byte_valid) begin
                got[got_n % 256] = byte_data;
                got_n++;
            end
            if (frame_done) done_n++;
            if (sym_err) err_n++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input logic [1:0] s);
        case (s)
            2'd0: return 8'hBF;
            2'd1: return 8'hEF;
            2'd2: return 8'hFB;
            default: return 8'hFE;
        endcase
    endfunction

    function automatic logic [7:0] pack4(input logic [1:0] s0, input logic [1:0] s1,
                                         input logic [1:0] s2, input logic [1:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    // One slot: drive at a falling edge, return at the next falling edge.
    task automatic slot(input logic b);
        if (use_gaps && ($urandom % 4 == 0)) begin
            slot_valid = 1'b0;
            repeat (1 + $urandom % 3) @(negedge clk);
        end
        slot_valid = 1'b1;
        slot_bit   = b;
        @(negedge clk);
        slot_valid = 1'b0;
        slot_bit   = 1'b1;
    endtask

    task automatic window(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) slot(w[i]);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 0; k < 4; k++) window(code_of(v[2*k +: 2]));
    endtask

    task automatic idle(input int n);
        slot_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int b0, d0, e0, nb;
        logic [7:0] exp_b [0:63];
        void'($urandom(32'h5EED_1234));

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 outputs in reset", {byte_valid, frame_done, sym_err, len_ovf}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", {byte_valid, frame_done, sym_err, len_ovf}, 0);
        chk("R1 byte_len after reset", int'(byte_len), 0);

        // R2: valid-looking groups without a frame start are ignored
        b0 = got_n; d0 = done_n; e0 = err_n;
        window(8'hEF); window(8'hFB); window(8'hFE); window(8'hBF); window(8'hDF);
        idle(2);
        chk("R2 no bytes before frame start", got_n - b0, 0);
        chk("R2 no pulses before frame start", (done_n - d0) + (err_n - e0), 0);

        // R3/R4/R8/R5: directed byte 0,1,2,3 -> 0xE4 with cycle timing
        window(8'h7B);
        chk("R8 byte_len cleared at frame start", int'(byte_len), 0);
        window(code_of(2'd0)); window(code_of(2'd1)); window(code_of(2'd2));
        chk("R4 no strobe before fourth symbol", int'(byte_valid), 0);
        window(code_of(2'd3));
        chk("R4 strobe after fourth symbol", int'(byte_valid), 1);
        chk("R4 packed byte", int'(byte_data), 8'hE4);
        chk("R8 byte_len with strobe", int'(byte_len), 1);
        @(negedge clk);
        chk("R4 strobe lasts one cycle", int'(byte_valid), 0);
        window(8'hDF);
        chk("R5 frame_done after end group", int'(frame_done), 1);
        @(negedge clk);
        chk("R5 frame_done lasts one cycle", int'(frame_done), 0);
        chk("R8 byte_len holds after frame", int'(byte_len), 1);

        // R5: groups after end of frame are ignored
        b0 = got_n;
        send_byte(8'h3C);
        idle(2);
        chk("R5 bytes ignored after frame end", got_n - b0, 0);

        // R3: each symbol code in all four positions
        for (int s = 0; s < 4; s++) begin
            b0 = got_n;
            window(8'h7B);
            for (int k = 0; k < 4; k++) window(code_of(2'(s)));
            window(8'hDF);
            idle(1);
            chk("R3 symbol code count", got_n - b0, 1);
            chk("R3 symbol code value", int'(got[b0 % 256]),
                int'(pack4(2'(s), 2'(s), 2'(s), 2'(s))));
        end

        // R7: partial byte at end of frame gives no strobe
        b0 = got_n; d0 = done_n;
        window(8'h7B);
        window(code_of(2'd2)); window(code_of(2'd1));
        window(8'hDF);
        idle(1);
        chk("R7 partial byte dropped", got_n - b0, 0);
        chk("R7 frame still completes", done_n - d0, 1);
        chk("R7 byte_len zero", int'(byte_len), 0);

        // R6: malformed group aborts the frame
        b0 = got_n; d0 = done_n; e0 = err_n;
        window(8'h7B);
        send_byte(8'h96);
        window(code_of(2'd3));
        window(8'h00);
        chk("R6 sym_err after bad group", int'(sym_err), 1);
        @(negedge clk);
        chk("R6 sym_err lasts one cycle", int'(sym_err), 0);
        send_byte(8'h11);
        window(8'hDF);
        idle(1);
        chk("R6 one byte before abort", got_n - b0, 1);
        chk("R6 byte value before abort", int'(got[b0 % 256]), 8'h96);
        chk("R6 no frame_done after abort", done_n - d0, 0);
        chk("R6 single error pulse", err_n - e0, 1);
        chk("R8 byte_len holds after abort", int'(byte_len), 1);

        // R11: history refilled after a judged group
        b0 = got_n; e0 = err_n;
        window(8'h7B);
        window(8'h77);
        slot(1'b1); slot(1'b0); slot(1'b1); slot(1'b1);
        send_byte(8'h00);
        idle(2);
        chk("R11 one error for bad group", err_n - e0, 1);
        chk("R11 no frame from stale history", got_n - b0, 0);

        // R9: length ceiling and overflow in the same cycle as the strobe
        window(8'h7B);
        for (int n = 1; n <= MAX_LEN + 1; n++) begin
            send_byte(8'(n));
            if (n == MAX_LEN) begin
                chk("R9 no overflow at ceiling", int'(len_ovf), 0);
                chk("R9 length at ceiling", int'(byte_len), MAX_LEN);
            end
        end
        chk("R9 strobe on extra byte", int'(byte_valid), 1);
        chk("R9 overflow rises with strobe", int'(len_ovf), 1);
        chk("R9 length saturated", int'(byte_len), MAX_LEN);
        window(8'hDF);
        chk("R9 overflow sticky", int'(len_ovf), 1);
        window(8'h7B);
        chk("R9 overflow cleared at frame start", int'(len_ovf), 0);
        chk("R8 length cleared at frame start", int'(byte_len), 0);
        window(8'hDF);

        // R4/R8/R10: random frames with random idle gaps
        use_gaps = 1;
        for (int f = 0; f < 24; f++) begin
            nb = $urandom % 7;
            for (int i = 0; i < nb; i++) exp_b[i] = 8'($urandom);
            b0 = got_n; d0 = done_n;
            window(8'h7B);
            for (int i = 0; i < nb; i++) send_byte(exp_b[i]);
            window(8'hDF);
            idle(2);
            chk("R10 random frame byte count", got_n - b0, nb);
            for (int i = 0; i < nb; i++)
                chk("R4 random frame byte", int'(got[(b0 + i) % 256]), int'(exp_b[i]));
            chk("R8 random frame length", int'(byte_len), nb);
            chk("R5 random frame done", done_n - d0, 1);
        end
        use_gaps = 0;

        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule